// File: doc/BRIEF.md
# Manchester Frame Receiver

This block recovers frames from a single Manchester-coded serial line. A frame opens with a start bit whose value is always one. Data bits follow, each coded by the direction of the transition at the middle of its bit cell. Two level-coded stop positions close the frame. Timing is recovered by measuring the time between line transitions, counted in sample ticks against a programmable bit period. Transitions near a cell boundary are told apart from mid-cell transitions by that measured interval.

Data bits are assembled in a 17-bit shift register. The frame length and the bit order are selectable. When the stop positions have been sampled, the block presents the right-justified word, both stop levels and a one-cycle valid pulse. An automatic mode accepts either 16 or 17 data bits. It decides from the seventeenth cell whether that cell holds a data bit or the first stop position, and reports the result in a length flag. A data cell that lacks its mid-cell transition ends the frame with a framing-error pulse.

Top module: `manch_rx`

## Requirements
- R1: While `rst` is high, and after its release until a frame completes, `rx_valid`, `frame_err`, `len17_flag`, `stop_bits` and `rx_data` are all zero.
- R2: The line idles high. A frame is accepted only when the start cell goes low and then rises at its centre, with the low phase lasting between a quarter and three quarters of a bit period. A low pulse shorter than that, or a low level held longer than that, produces neither `rx_valid` nor `frame_err`.
- R3: A data bit is one when its mid-cell transition rises and zero when it falls. A transition arriving less than three quarters of a bit period after the previous mid-cell transition is a boundary transition and is skipped.
- R4: `len_sel` picks the number of data bits: 0→5, 1→6, 2→7, 3→8, 4→9, 5→13, 6→14, 7→15, 8→16, 9→17, 10→automatic 16/17. Codes 11 to 15 mean 8.
- R5: With `msb_first`=1, the first data bit received lands in bit N-1 of `rx_data`. With `msb_first`=0, it lands in bit 0. Bits N to 16 of `rx_data` read zero.
- R6: In automatic mode, a mid-cell transition in the seventeenth cell gives a 17-bit word with `len17_flag`=1. Without one, the word has 16 bits, `len17_flag`=0, and that cell is taken as the first stop position. In every other mode, `len17_flag` is 0 with each valid frame.
- R7: `stop_bits[0]` holds the line level at the centre of the first stop position, and `stop_bits[1]` holds the level at the centre of the second. Any combination of levels is accepted.
- R8: Each completed frame gives exactly one `rx_valid` pulse, one clock cycle wide. `rx_data`, `stop_bits` and `len17_flag` then hold their values until the next frame completes.
- R9: A data cell with no mid-cell transition by 1.25 bit periods after the previous one (other than the seventeenth cell in automatic mode) gives a one-cycle `frame_err` pulse. No `rx_valid` follows, and `rx_data` is unchanged.
- R10: The block receives only while both `rx_enable` and `manch_mode` are high. Lowering either one abandons a frame in progress without `rx_valid` or `frame_err`. Once both are high again, frames are received normally.
- R11: `bit_ticks` is the bit period in `sample_en` ticks, and mid-cell transitions are accepted within ±¼ period of it. Only cycles with `sample_en` high advance timing, so the same frames decode when ticks and line rate are scaled together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial Manchester input, idle high |
| rx_enable | input | 1 | Global receive enable |
| manch_mode | input | 1 | Manchester mode select |
| len_sel | input | 4 | Data length code (R4) |
| msb_first | input | 1 | 1: first received bit is the MSB |
| bit_ticks | input | CNT_W | Bit period in sample ticks |
| sample_en | input | 1 | Sample tick enable |
| rx_data | output | 17 | Received word, right-justified |
| stop_bits | output | 2 | Levels at the two stop positions |
| rx_valid | output | 1 | One-cycle frame-complete pulse |
| len17_flag | output | 1 | Automatic mode picked 17 bits |
| frame_err | output | 1 | One-cycle missing-transition pulse |

## Verification
The bench targets the seventeenth cell in automatic mode. It sends 16-bit frames whose last data bit and first stop level produce either no transition or only a boundary transition. A design that mistook that boundary transition for data would report 17 bits with a shifted word. It also sends truncated frames, inverted or glitchy start cells, and frames cut off by a dropped enable. A design that missed any of these would raise `rx_valid` with garbage, keep no error, or overwrite the held word. Finally it runs the ten lengths in both bit orders at two bit periods and with a halved tick rate. This catches misaligned right-justification, reversed order and timing that counts clock cycles instead of ticks.

// File: rtl/manch_pkg.sv
`timescale 1ns/1ps
package manch_pkg;

    localparam int WORD_W    = 17;
    localparam int LEN_W     = $clog2(WORD_W + 1);
    localparam int BIT_CNT_W = 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HUNT,
        S_DATA,
        S_STOP1,
        S_STOP2,
        S_DONE
    } rx_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] nbits;
        logic             auto16;
    } len_cfg_t;

    typedef struct packed {
        logic lvl;
        logic chg;
        logic rising;
    } line_ev_t;

    typedef struct packed {
        logic half_ok;
        logic hunt_late;
        logic full_ok;
        logic late;
        logic at_mid;
        logic at_stop2;
    } tmr_flags_t;

    function automatic len_cfg_t decode_len(input logic [3:0] code);
        len_cfg_t c;
        c.auto16 = 1'b0;
        unique case (code)
            4'd0:    c.nbits = LEN_W'(5);
            4'd1:    c.nbits = LEN_W'(6);
            4'd2:    c.nbits = LEN_W'(7);
            4'd3:    c.nbits = LEN_W'(8);
            4'd4:    c.nbits = LEN_W'(9);
            4'd5:    c.nbits = LEN_W'(13);
            4'd6:    c.nbits = LEN_W'(14);
            4'd7:    c.nbits = LEN_W'(15);
            4'd8:    c.nbits = LEN_W'(16);
            4'd9:    c.nbits = LEN_W'(17);
            4'd10: begin
                c.nbits  = LEN_W'(17);
                c.auto16 = 1'b1;
            end
            default: c.nbits = LEN_W'(8);
        endcase
        return c;
    endfunction

endpackage

// File: rtl/manch_line_sync.sv
`timescale 1ns/1ps
module manch_line_sync
    import manch_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter logic IDLE_LVL    = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     line_i,
    input  logic     tick_i,
    output line_ev_t ev_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   smp_q;
    logic                   cur;

    assign cur = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= {SYNC_STAGES{IDLE_LVL}};
            smp_q  <= IDLE_LVL;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            if (tick_i) smp_q <= cur;
        end
    end

    always_comb begin
        ev_o.lvl    = cur;
        ev_o.chg    = tick_i && (cur != smp_q);
        ev_o.rising = tick_i && cur && !smp_q;
    end

endmodule

// File: rtl/manch_interval_timer.sv
`timescale 1ns/1ps
module manch_interval_timer
    import manch_pkg::*;
#(
    parameter int CNT_W = BIT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] bit_ticks_i,
    output tmr_flags_t       flags_o
);

    localparam int TMR_W = CNT_W + 2;

    logic [TMR_W-1:0] cnt_q;
    logic [TMR_W-1:0] elapsed;
    logic [TMR_W-1:0] per, qtr, half, stop2_at;
    logic [TMR_W-1:0] half_hi, full_lo, full_hi;

    always_comb begin
        per      = {2'b00, bit_ticks_i};
        qtr      = per >> 2;
        half     = per >> 1;
        half_hi  = half + qtr;
        full_lo  = per - qtr;
        full_hi  = per + qtr;
        stop2_at = per << 1;
        elapsed  = (cnt_q == '1) ? cnt_q : cnt_q + TMR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= clear_i ? '0 : elapsed;
        end
    end

    always_comb begin
        flags_o.half_ok   = (elapsed >= qtr) && (elapsed <= half_hi);
        flags_o.hunt_late = (elapsed > half_hi);
        flags_o.full_ok   = (elapsed >= full_lo) && (elapsed <= full_hi);
        flags_o.late      = (elapsed > full_hi);
        flags_o.at_mid    = (elapsed == per);
        flags_o.at_stop2  = (elapsed == stop2_at);
    end

    // R11: timing advances only on sample ticks
    a_r11_count_only_on_tick: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(cnt_q));

endmodule

// File: rtl/manch_shift17.sv
`timescale 1ns/1ps
module manch_shift17
    import manch_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int CW  = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_i,
    input  logic          shift_i,
    input  logic          bit_i,
    input  logic          msb_first_i,
    output logic [W-1:0]  word_o,
    output logic [CW-1:0] count_o
);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (shift_i) begin
            cnt_q <= cnt_q + CW'(1);
            if (msb_first_i) sh_q <= {sh_q[W-2:0], bit_i};
            else             sh_q <= {bit_i, sh_q[W-1:1]};
        end
    end

    always_comb begin
        if (msb_first_i) word_o = sh_q;
        else             word_o = sh_q >> (CW'(W) - cnt_q);
    end

    assign count_o = cnt_q;

    // R4: never more bits than the register holds
    a_r4_shift_in_range: assert property (@(posedge clk) disable iff (rst)
        shift_i |-> (cnt_q < CW'(W)));

endmodule

// File: rtl/manch_rx.sv
`timescale 1ns/1ps
module manch_rx
    import manch_pkg::*;
#(
    parameter int CNT_W = BIT_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic              rx_enable,
    input  logic              manch_mode,
    input  logic [3:0]        len_sel,
    input  logic              msb_first,
    input  logic [CNT_W-1:0]  bit_ticks,
    input  logic              sample_en,
    output logic [WORD_W-1:0] rx_data,
    output logic [1:0]        stop_bits,
    output logic              rx_valid,
    output logic              len17_flag,
    output logic              frame_err
);

    rx_state_e   state_q, state_d;
    line_ev_t    ev;
    tmr_flags_t  tf;
    len_cfg_t    cfg;
    logic        run, cfg_auto;
    logic        tmr_clear, sh_clear, sh_shift;
    logic        cap_mid, cap_s1, s1_from_mid, load_out, err_set;
    logic        mid_lvl_q, s1_q;
    logic [WORD_W-1:0] sh_word;
    logic [LEN_W-1:0]  sh_cnt;
    logic [WORD_W-1:0] data_q;
    logic [1:0]        stop_q;
    logic              flag_q, err_q;

    assign run      = rx_enable && manch_mode;
    assign cfg      = decode_len(len_sel);
    assign cfg_auto = cfg.auto16;

    manch_line_sync #(.SYNC_STAGES(2), .IDLE_LVL(1'b1)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .line_i (rx_line),
        .tick_i (sample_en),
        .ev_o   (ev)
    );

    manch_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (sample_en),
        .clear_i     (tmr_clear),
        .bit_ticks_i (bit_ticks),
        .flags_o     (tf)
    );

    manch_shift17 #(.W(WORD_W), .CW(LEN_W)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (sh_clear),
        .shift_i     (sh_shift),
        .bit_i       (ev.lvl),
        .msb_first_i (msb_first),
        .word_o      (sh_word),
        .count_o     (sh_cnt)
    );

    always_comb begin
        state_d     = state_q;
        tmr_clear   = 1'b0;
        sh_clear    = 1'b0;
        sh_shift    = 1'b0;
        cap_mid     = 1'b0;
        cap_s1      = 1'b0;
        s1_from_mid = 1'b0;
        load_out    = 1'b0;
        err_set     = 1'b0;
        if (!run) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (ev.chg && !ev.rising) begin
                        state_d   = S_HUNT;
                        tmr_clear = 1'b1;
                    end
                end
                S_HUNT: begin
                    if (ev.rising) begin
                        if (tf.half_ok) begin
                            state_d   = S_DATA;
                            tmr_clear = 1'b1;
                            sh_clear  = 1'b1;
                        end else begin
                            state_d = S_IDLE;
                        end
                    end else if (sample_en && tf.hunt_late) begin
                        state_d = S_IDLE;
                    end
                end
                S_DATA: begin
                    if (sample_en && tf.at_mid) cap_mid = 1'b1;
                    if (ev.chg && tf.full_ok) begin
                        sh_shift  = 1'b1;
                        tmr_clear = 1'b1;
                        if (sh_cnt + LEN_W'(1) == cfg.nbits) state_d = S_STOP1;
                    end else if (sample_en && tf.late) begin
                        if (cfg.auto16 && sh_cnt == LEN_W'(16)) begin
                            s1_from_mid = 1'b1;
                            state_d     = S_STOP2;
                        end else begin
                            err_set = 1'b1;
                            state_d = S_IDLE;
                        end
                    end
                end
                S_STOP1: begin
                    if (sample_en && tf.at_mid) begin
                        cap_s1  = 1'b1;
                        state_d = S_STOP2;
                    end
                end
                S_STOP2: begin
                    if (sample_en && tf.at_stop2) begin
                        load_out = 1'b1;
                        state_d  = S_DONE;
                    end
                end
                S_DONE:  state_d = S_IDLE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            mid_lvl_q <= 1'b0;
            s1_q      <= 1'b0;
            data_q    <= '0;
            stop_q    <= '0;
            flag_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_set;
            if (cap_mid)     mid_lvl_q <= ev.lvl;
            if (cap_s1)      s1_q      <= ev.lvl;
            if (s1_from_mid) s1_q      <= mid_lvl_q;
            if (load_out) begin
                data_q <= sh_word;
                stop_q <= {ev.lvl, s1_q};
                flag_q <= cfg.auto16 && (sh_cnt == LEN_W'(17));
            end
        end
    end

    assign rx_data    = data_q;
    assign stop_bits  = stop_q;
    assign len17_flag = flag_q;
    assign frame_err  = err_q;
    assign rx_valid   = (state_q == S_DONE);

    // R8: completion pulse lasts one cycle
    a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R10: nothing reported once reception is switched off
    a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!rx_valid && !frame_err));

    // R9: an error never coincides with a completed frame
    a_r9_err_excludes_valid: assert property (@(posedge clk) disable iff (rst)
        !(frame_err && rx_valid));

    // R9: the held word survives a framing error
    a_r9_data_held_on_err: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> $stable(rx_data));

    // R6: the length flag is only raised by the automatic mode
    a_r6_flag_needs_auto: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !$past(cfg_auto)) |-> !len17_flag);

endmodule

// File: tb/manch_rx_bench.sv
`timescale 1ns/1ps
module manch_rx_bench;
    import manch_pkg::*;

    typedef struct packed {
        logic [3:0]  code;
        logic        msb;
        logic [4:0]  n;
        logic [16:0] seq;
        logic        s1;
        logic        s2;
        logic [3:0]  hb;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'd3,  1'b0, 5'd8,  17'h000A5, 1'b1, 1'b1, 4'd4},
        '{4'd3,  1'b1, 5'd8,  17'h0001D, 1'b1, 1'b1, 4'd4},
        '{4'd0,  1'b0, 5'd5,  17'h00015, 1'b1, 1'b1, 4'd4},
        '{4'd1,  1'b1, 5'd6,  17'h0002B, 1'b1, 1'b0, 4'd4},
        '{4'd2,  1'b0, 5'd7,  17'h00055, 1'b0, 1'b1, 4'd4},
        '{4'd4,  1'b1, 5'd9,  17'h001A3, 1'b1, 1'b0, 4'd4},
        '{4'd5,  1'b0, 5'd13, 17'h01ABC, 1'b1, 1'b1, 4'd6},
        '{4'd6,  1'b1, 5'd14, 17'h02D5A, 1'b0, 1'b0, 4'd6},
        '{4'd7,  1'b0, 5'd15, 17'h07FFF, 1'b0, 1'b0, 4'd4},
        '{4'd8,  1'b1, 5'd16, 17'h0C3A5, 1'b1, 1'b1, 4'd4},
        '{4'd9,  1'b0, 5'd17, 17'h1ACE1, 1'b1, 1'b1, 4'd4},
        '{4'd10, 1'b1, 5'd17, 17'h1F00F, 1'b1, 1'b1, 4'd4},
        '{4'd10, 1'b0, 5'd16, 17'h08001, 1'b1, 1'b1, 4'd4},
        '{4'd10, 1'b0, 5'd16, 17'h01234, 1'b1, 1'b0, 4'd6},
        '{4'd10, 1'b1, 5'd16, 17'h08F00, 1'b0, 1'b1, 4'd4}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst, rx_line, rx_enable, manch_mode, msb_first, sample_en, div;
    logic [3:0]  len_sel;
    logic [15:0] bit_ticks;
    logic [16:0] rx_data;
    logic [1:0]  stop_bits;
    logic        rx_valid, len17_flag, frame_err;

    int checks = 0, errors = 0;
    int vcount = 0, ecount = 0, vrun = 0, vrun_max = 0;
    bit finished = 1'b0;

    manch_rx u_manch_rx (
        .clk(clk), .rst(rst), .rx_line(rx_line), .rx_enable(rx_enable),
        .manch_mode(manch_mode), .len_sel(len_sel), .msb_first(msb_first),
        .bit_ticks(bit_ticks), .sample_en(sample_en), .rx_data(rx_data),
        .stop_bits(stop_bits), .rx_valid(rx_valid), .len17_flag(len17_flag),
        .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            vcount++;
            vrun++;
            if (vrun > vrun_max) vrun_max = vrun;
        end else begin
            vrun = 0;
        end
        if (frame_err) ecount++;
    end

    initial begin
        div = 1'b0;
        sample_en = 1'b1;
        forever begin
            @(negedge clk);
            sample_en = div ? ~sample_en : 1'b1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold(input logic lvl, input int n);
        rx_line = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [16:0] seq, input int n, input logic s1,
                              input logic s2, input int hb);
        hold(1'b0, hb);
        hold(1'b1, hb);
        for (int i = 0; i < n; i++) begin
            hold(~seq[i], hb);
            hold(seq[i], hb);
        end
        hold(s1, 2 * hb);
        hold(s2, 2 * hb);
        hold(1'b1, 6 * hb);
    endtask

    function automatic logic [16:0] exp_word(input logic [16:0] seq, input int n,
                                             input logic msb);
        logic [16:0] w;
        w = '0;
        for (int i = 0; i < 17; i++)
            if (i < n) begin
                if (msb) w[n-1-i] = seq[i];
                else     w[i]     = seq[i];
            end
        return w;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired (R8) actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int pv, pe;
        logic [16:0] held;
        rst = 1'b1; rx_line = 1'b1; rx_enable = 1'b1; manch_mode = 1'b1;
        len_sel = 4'd3; msb_first = 1'b0; bit_ticks = 16'd8;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(rx_valid == 0 && frame_err == 0, "R1 strobes", {rx_valid, frame_err}, 0);
        check(rx_data == 0 && stop_bits == 0 && len17_flag == 0, "R1 outputs",
              rx_data, 0);
        rst = 1'b0;
        repeat (8) @(negedge clk);
        check(rx_valid == 0 && rx_data == 0, "R1 after release", rx_data, 0);

        // R3 R4 R5 R6 R7 R8: table of frames
        for (int v = 0; v < NV; v++) begin
            len_sel   = VECS[v].code;
            msb_first = VECS[v].msb;
            bit_ticks = 16'(2 * VECS[v].hb);
            pv = vcount;
            send_frame(VECS[v].seq, VECS[v].n, VECS[v].s1, VECS[v].s2, VECS[v].hb);
            check(vcount == pv + 1, $sformatf("R8 valid count vec %0d", v), vcount - pv, 1);
            check(rx_data == exp_word(VECS[v].seq, VECS[v].n, VECS[v].msb),
                  $sformatf("R3/R4/R5 data vec %0d", v), rx_data,
                  exp_word(VECS[v].seq, VECS[v].n, VECS[v].msb));
            check(stop_bits == {VECS[v].s2, VECS[v].s1},
                  $sformatf("R7 stop vec %0d", v), stop_bits, {VECS[v].s2, VECS[v].s1});
            check(len17_flag == (VECS[v].code == 4'd10 && VECS[v].n == 5'd17),
                  $sformatf("R6 flag vec %0d", v), len17_flag,
                  (VECS[v].code == 4'd10 && VECS[v].n == 5'd17));
        end
        check(ecount == 0, "R9 no spurious error", ecount, 0);

        // R8: one-cycle pulse, held outputs
        check(vrun_max == 1, "R8 pulse width", vrun_max, 1);
        held = rx_data;
        repeat (50) @(negedge clk);
        check(rx_data == held, "R8 hold", rx_data, held);

        // R9: truncated frame
        len_sel = 4'd3; msb_first = 1'b0; bit_ticks = 16'd8;
        pv = vcount; pe = ecount; held = rx_data;
        send_frame(17'h00005, 3, 1'b1, 1'b1, 4);
        check(ecount == pe + 1, "R9 error pulse", ecount - pe, 1);
        check(vcount == pv, "R9 no valid", vcount - pv, 0);
        check(rx_data == held, "R9 data kept", rx_data, held);

        // R2: inverted start and short glitch
        pv = vcount; pe = ecount;
        hold(1'b1, 4); hold(1'b0, 24); hold(1'b1, 24);
        check(vcount == pv && ecount == pe, "R2 inverted start", vcount - pv, 0);
        hold(1'b0, 1); hold(1'b1, 32);
        check(vcount == pv && ecount == pe, "R2 glitch", vcount - pv, 0);

        // R10: disabled reception
        rx_enable = 1'b0;
        send_frame(17'h000A5, 8, 1'b1, 1'b1, 4);
        check(vcount == pv, "R10 enable low", vcount - pv, 0);
        rx_enable = 1'b1; manch_mode = 1'b0;
        send_frame(17'h000A5, 8, 1'b1, 1'b1, 4);
        check(vcount == pv, "R10 mode off", vcount - pv, 0);
        manch_mode = 1'b1;
        fork
            send_frame(17'h000A5, 8, 1'b1, 1'b1, 4);
            begin
                repeat (40) @(negedge clk);
                rx_enable = 1'b0;
            end
        join
        check(vcount == pv && ecount == pe, "R10 abort", vcount - pv, 0);
        rx_enable = 1'b1;
        repeat (10) @(negedge clk);
        send_frame(17'h0005A, 8, 1'b0, 1'b1, 4);
        check(vcount == pv + 1 && rx_data == 17'h0005A, "R10 recovery", rx_data, 17'h5A);

        // R11: halved tick rate, same bit_ticks, doubled line period
        div = 1'b1; bit_ticks = 16'd8; len_sel = 4'd8; msb_first = 1'b1;
        repeat (4) @(negedge clk);
        pv = vcount;
        send_frame(17'h0B00C, 16, 1'b1, 1'b1, 8);
        check(vcount == pv + 1, "R11 tick valid", vcount - pv, 1);
        check(rx_data == exp_word(17'h0B00C, 16, 1'b1), "R11 tick data", rx_data,
              exp_word(17'h0B00C, 16, 1'b1));
        div = 1'b0;

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule